// File: doc/BRIEF.md
# Indirect Register Window Controller

This block is the software-visible front end of an interrupt router. The bus sees only two addresses: an 8-bit select register and a 32-bit data window. The value in the select register chooses what the window shows. It can show a 4-bit identifier, a read-only version word, or one half of a 64-bit redirection entry for each input pin.

Each access is a single cycle. Read data is combinational from the current state, in the cycle the access is presented. Software cannot overwrite the status bits that hardware owns in each entry. The remote-IRR bit is set and cleared by pulses from the delivery logic. The delivery-status bit follows a busy input. A write that leaves an entry edge-triggered clears remote-IRR.

The block also reports two events to the rest of the router, each as a registered one-cycle strobe:
- a write that flips an entry's mask bit;
- any write to an entry that leaves it level-triggered.

Top module: `iwin_ctrl`

## Requirements
- R1: A bus write to offset 0x00 loads the select register with data bits 7:0 only. A read of offset 0x00 returns the select value zero-extended to 32 bits.
- R2: With select 0x01, the window reads NPINS-1 in bits 23:16 and the VERSION parameter in bits 7:0. All other bits read zero.
- R3: With select 0x00 or 0x02, the window reads the 4-bit identifier in bits 27:24 and zero elsewhere. A window write with select 0x00 loads the identifier from data bits 27:24.
- R4: Window writes with select 0x01 or 0x02 change nothing.
- R5: Entry n sits at select 0x10+2n. The even select holds entry bits 31:0 and the odd select holds bits 63:32. The fields are: vector in bits 7:0, delivery status in bit 12, remote-IRR in bit 14, trigger mode in bit 15 (1 = level), and mask in bit 16.
- R6: A window read whose select is in 0x03..0x0F, or names an entry at or beyond NPINS, returns 0xFFFFFFFF.
- R7: Remote-IRR behaves as follows:
  - A write keeps remote-IRR.
  - A write leaves delivery status equal to the busy input as registered on the previous clock.
  - If the entry is edge-triggered after the write, remote-IRR becomes 0 and stays 0.
  - A set pulse makes remote-IRR 1 only on a level-triggered entry.
- R8: After reset every entry reads 0x00010000 (low half) and 0x00000000 (high half). The select register and the identifier are zero.
- R9: The clock edge after a low-half write that changes an entry's mask bit, `mask_chg_vld` is high for one cycle, with the pin number and the new mask value. It stays low when the mask does not change.
- R10: The clock edge after any write to either half of an entry that leaves it level-triggered, `lvl_wr_vld` is high for one cycle with the pin number. It stays low when the entry is left edge-triggered.
- R11: Offsets other than 0x00 and 0x10 read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| hw_rirr_set | input | NPINS | Per-pin remote-IRR set pulse |
| hw_rirr_clr | input | NPINS | Per-pin remote-IRR clear pulse |
| hw_busy | input | NPINS | Per-pin delivery-pending level |
| mask_chg_vld | output | 1 | Mask flipped by last write |
| mask_chg_pin | output | PIN_W | Pin whose mask flipped |
| mask_chg_val | output | 1 | New mask value |
| lvl_wr_vld | output | 1 | Level entry rewritten |
| lvl_wr_pin | output | PIN_W | Pin that was rewritten |

## Verification
A software write to an entry and a remote-IRR pulse from the delivery logic can land in the same clock. The bench provokes this by raising the set pulse in the very cycle of a window write.

Two outcomes are judged by reading the entry back afterwards:
- When the write makes the entry edge-triggered, the pulse must be lost and remote-IRR must read 0.
- When the write leaves the entry level-triggered, the pulse must win and remote-IRR must read 1.

// File: rtl/iwin_pkg.sv
package iwin_pkg;
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;
  localparam logic [7:0] IX_ID   = 8'h00;
  localparam logic [7:0] IX_VER  = 8'h01;
  localparam logic [7:0] IX_ARB  = 8'h02;
  localparam logic [7:0] IX_TBL  = 8'h10;
  localparam int B_DLV  = 12;
  localparam int B_RIRR = 14;
  localparam int B_TRIG = 15;
  localparam int B_MASK = 16;
  localparam logic [63:0] ENT_RST = 64'h0000_0000_0001_0000;

  function automatic logic [31:0] ver_word(int unsigned npins, logic [7:0] ver);
    return {8'h00, 8'(npins - 1), 8'h00, ver};
  endfunction

  function automatic logic [31:0] id_word(logic [3:0] id);
    return {4'h0, id, 24'h000000};
  endfunction

  // entry number addressed by a select value (valid when sel >= IX_TBL)
  function automatic logic [7:0] tbl_slot(logic [7:0] sel);
    logic [7:0] d;
    d = sel - IX_TBL;
    return {1'b0, d[7:1]};
  endfunction
endpackage

// File: rtl/iwin_entry.sv
module iwin_entry
  import iwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  input  logic        rirr_clr,
  input  logic        busy,
  output logic [63:0] ent_q,
  output logic        mask_flip,
  output logic        lvl_write
);
  logic [63:0] ent_d;

  always_comb begin
    ent_d = ent_q;
    if (wr_lo) ent_d[31:0]  = wdata;
    if (wr_hi) ent_d[63:32] = wdata;
    ent_d[B_DLV] = busy;
    if (!ent_d[B_TRIG])  ent_d[B_RIRR] = 1'b0;
    else if (rirr_set)   ent_d[B_RIRR] = 1'b1;
    else if (rirr_clr)   ent_d[B_RIRR] = 1'b0;
    else                 ent_d[B_RIRR] = ent_q[B_RIRR];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ent_q <= ENT_RST;
    else        ent_q <= ent_d;
  end

  assign mask_flip = wr_lo && (wdata[B_MASK] != ent_q[B_MASK]);
  assign lvl_write = (wr_lo || wr_hi) && ent_d[B_TRIG];
endmodule

// File: rtl/iwin_rdmux.sv
module iwin_rdmux
  import iwin_pkg::*;
#(
  parameter int unsigned NPINS   = 24,
  parameter logic [7:0]  VERSION = 8'h11
) (
  input  logic [7:0]          addr,
  input  logic [7:0]          sel_q,
  input  logic [3:0]          id_q,
  input  logic [NPINS*64-1:0] tbl_flat,
  output logic [31:0]         rdata
);
  localparam logic [7:0] NPINS_B = 8'(NPINS);

  logic [7:0]  slot;
  logic [31:0] win;

  assign slot = tbl_slot(sel_q);

  always_comb begin
    win = 32'hFFFF_FFFF;
    if (sel_q == IX_ID || sel_q == IX_ARB) begin
      win = id_word(id_q);
    end else if (sel_q == IX_VER) begin
      win = ver_word(NPINS, VERSION);
    end else if (sel_q >= IX_TBL && slot < NPINS_B) begin
      for (int i = 0; i < int'(NPINS); i++) begin
        if (slot == 8'(i))
          win = sel_q[0] ? tbl_flat[i*64+32 +: 32] : tbl_flat[i*64 +: 32];
      end
    end
  end

  always_comb begin
    case (addr)
      OFS_SEL: rdata = {24'h0, sel_q};
      OFS_WIN: rdata = win;
      default: rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/iwin_strobe.sv
module iwin_strobe #(
  parameter int unsigned NPINS = 24,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] flip,
  input  logic [NPINS-1:0] lvl,
  input  logic             mask_new,
  output logic             mask_chg_vld,
  output logic [PIN_W-1:0] mask_chg_pin,
  output logic             mask_chg_val,
  output logic             lvl_wr_vld,
  output logic [PIN_W-1:0] lvl_wr_pin
);
  logic [PIN_W-1:0] flip_ix, lvl_ix;

  always_comb begin
    flip_ix = '0;
    lvl_ix  = '0;
    for (int i = 0; i < int'(NPINS); i++) begin
      if (flip[i]) flip_ix = PIN_W'(i);
      if (lvl[i])  lvl_ix  = PIN_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_chg_vld <= 1'b0;
      mask_chg_pin <= '0;
      mask_chg_val <= 1'b0;
      lvl_wr_vld   <= 1'b0;
      lvl_wr_pin   <= '0;
    end else begin
      mask_chg_vld <= |flip;
      mask_chg_pin <= flip_ix;
      mask_chg_val <= mask_new;
      lvl_wr_vld   <= |lvl;
      lvl_wr_pin   <= lvl_ix;
    end
  end
endmodule

// File: rtl/iwin_ctrl.sv
module iwin_ctrl
  import iwin_pkg::*;
#(
  parameter int unsigned NPINS   = 24,
  parameter logic [7:0]  VERSION = 8'h11,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] hw_rirr_set,
  input  logic [NPINS-1:0] hw_rirr_clr,
  input  logic [NPINS-1:0] hw_busy,
  output logic             mask_chg_vld,
  output logic [PIN_W-1:0] mask_chg_pin,
  output logic             mask_chg_val,
  output logic             lvl_wr_vld,
  output logic [PIN_W-1:0] lvl_wr_pin
);
  localparam logic [7:0] NPINS_B = 8'(NPINS);

  logic [7:0]          sel_q;
  logic [3:0]          id_q;
  logic                wr_sel, wr_win, slot_ok;
  logic [7:0]          slot;
  logic [NPINS*64-1:0] tbl_flat;
  logic [NPINS-1:0]    flip_v, lvl_v, trig_v, rirr_v;

  assign wr_sel  = bus_en && bus_we && bus_addr == OFS_SEL;
  assign wr_win  = bus_en && bus_we && bus_addr == OFS_WIN;
  assign slot    = tbl_slot(sel_q);
  assign slot_ok = sel_q >= IX_TBL && slot < NPINS_B;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 8'h00;
      id_q  <= 4'h0;
    end else begin
      if (wr_sel) sel_q <= bus_wdata[7:0];
      if (wr_win && sel_q == IX_ID) id_q <= bus_wdata[27:24];
    end
  end

  for (genvar g = 0; g < int'(NPINS); g++) begin : g_pin
    logic        hit;
    logic [63:0] ent_q;
    assign hit = wr_win && slot_ok && slot == 8'(g);
    iwin_entry u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lo     (hit && !sel_q[0]),
      .wr_hi     (hit && sel_q[0]),
      .wdata     (bus_wdata),
      .rirr_set  (hw_rirr_set[g]),
      .rirr_clr  (hw_rirr_clr[g]),
      .busy      (hw_busy[g]),
      .ent_q     (ent_q),
      .mask_flip (flip_v[g]),
      .lvl_write (lvl_v[g])
    );
    assign tbl_flat[g*64 +: 64] = ent_q;
    assign trig_v[g] = ent_q[B_TRIG];
    assign rirr_v[g] = ent_q[B_RIRR];
  end

  iwin_rdmux #(.NPINS(NPINS), .VERSION(VERSION)) u_rd (
    .addr     (bus_addr),
    .sel_q    (sel_q),
    .id_q     (id_q),
    .tbl_flat (tbl_flat),
    .rdata    (bus_rdata)
  );

  iwin_strobe #(.NPINS(NPINS)) u_stb (
    .clk          (clk),
    .rst_n        (rst_n),
    .flip         (flip_v),
    .lvl          (lvl_v),
    .mask_new     (bus_wdata[B_MASK]),
    .mask_chg_vld (mask_chg_vld),
    .mask_chg_pin (mask_chg_pin),
    .mask_chg_val (mask_chg_val),
    .lvl_wr_vld   (lvl_wr_vld),
    .lvl_wr_pin   (lvl_wr_pin)
  );
endmodule

// File: rtl/iwin_ctrl_chk.sv
module iwin_ctrl_chk #(
  parameter int unsigned NPINS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_we,
  input logic [7:0]       bus_addr,
  input logic [7:0]       wsel,
  input logic [3:0]       wid,
  input logic [31:0]      bus_rdata,
  input logic [7:0]       sel_q,
  input logic [3:0]       id_q,
  input logic [NPINS-1:0] trig_v,
  input logic [NPINS-1:0] rirr_v,
  input logic             mask_chg_vld
);
  logic wr0, wr_win, wr_other, rd_oob;
  assign wr0      = bus_en && bus_we && bus_addr == 8'h00;
  assign wr_win   = bus_en && bus_we && bus_addr == 8'h10;
  assign wr_other = bus_en && bus_we && bus_addr != 8'h00 && bus_addr != 8'h10;
  assign rd_oob   = bus_addr == 8'h10 &&
                    ((sel_q > 8'h02 && sel_q < 8'h10) ||
                     (sel_q >= 8'h10 && ({1'b0, sel_q} - 9'h10) >= 9'(2 * NPINS)));

  p_sel_low_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr0 |=> sel_q == $past(wsel));
  p_id_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && sel_q == 8'h00) |=> id_q == $past(wid));
  p_ro_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && (sel_q == 8'h01 || sel_q == 8'h02)) |=> $stable(id_q) && $stable(sel_q));
  p_oob_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oob |-> bus_rdata == 32'hFFFF_FFFF);
  p_edge_no_rirr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_v & ~trig_v) == '0);
  p_mask_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_chg_vld) |-> $past(wr_win));
  p_other_ofs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_other |=> $stable(sel_q) && $stable(id_q));
endmodule

bind iwin_ctrl iwin_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_en       (bus_en),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .wsel         (bus_wdata[7:0]),
  .wid          (bus_wdata[27:24]),
  .bus_rdata    (bus_rdata),
  .sel_q        (sel_q),
  .id_q         (id_q),
  .trig_v       (trig_v),
  .rirr_v       (rirr_v),
  .mask_chg_vld (mask_chg_vld)
);

// File: tb/test_iwin_ctrl.sv
module test_iwin_ctrl;
  localparam int NP = 24;
  localparam int PW = $clog2(NP);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0]    bus_addr = 8'h00;
  logic [31:0]   bus_wdata = 32'h0, bus_rdata;
  logic [NP-1:0] hw_rirr_set = '0, hw_rirr_clr = '0, hw_busy = '0;
  logic          mask_chg_vld, mask_chg_val, lvl_wr_vld;
  logic [PW-1:0] mask_chg_pin, lvl_wr_pin;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  iwin_ctrl #(.NPINS(NP), .VERSION(8'h11)) i_iwin_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_rirr_set(hw_rirr_set), .hw_rirr_clr(hw_rirr_clr), .hw_busy(hw_busy),
    .mask_chg_vld(mask_chg_vld), .mask_chg_pin(mask_chg_pin), .mask_chg_val(mask_chg_val),
    .lvl_wr_vld(lvl_wr_vld), .lvl_wr_pin(lvl_wr_pin));

  // {op(4): 0 write / 1 read, req(4), select(8), wdata(32), expected(32)}
  localparam int NV = 17;
  localparam logic [79:0] VEC [NV] = '{
    {4'd1, 4'd2, 8'h01, 32'h0,         32'h0017_0011}, // R2 version word
    {4'd0, 4'd3, 8'h00, 32'hA500_0000, 32'h0},         // R3 id load
    {4'd1, 4'd3, 8'h00, 32'h0,         32'h0500_0000}, // R3
    {4'd1, 4'd3, 8'h02, 32'h0,         32'h0500_0000}, // R3 arbitration alias
    {4'd0, 4'd4, 8'h01, 32'hFFFF_FFFF, 32'h0},         // R4
    {4'd0, 4'd4, 8'h02, 32'h0F00_0000, 32'h0},         // R4
    {4'd1, 4'd4, 8'h01, 32'h0,         32'h0017_0011}, // R4
    {4'd1, 4'd4, 8'h00, 32'h0,         32'h0500_0000}, // R4
    {4'd0, 4'd5, 8'h2E, 32'h0000_8030, 32'h0},         // R5 pin 15 low
    {4'd0, 4'd5, 8'h2F, 32'hAB00_0000, 32'h0},         // R5 pin 15 high
    {4'd1, 4'd5, 8'h2E, 32'h0,         32'h0000_8030}, // R5
    {4'd1, 4'd5, 8'h2F, 32'h0,         32'hAB00_0000}, // R5
    {4'd1, 4'd6, 8'h40, 32'h0,         32'hFFFF_FFFF}, // R6 first missing entry
    {4'd1, 4'd6, 8'h41, 32'h0,         32'hFFFF_FFFF}, // R6
    {4'd1, 4'd6, 8'h07, 32'h0,         32'hFFFF_FFFF}, // R6 gap below table
    {4'd1, 4'd8, 8'h12, 32'h0,         32'h0001_0000}, // R8 untouched entry
    {4'd1, 4'd6, 8'hFF, 32'h0,         32'hFFFF_FFFF}  // R6 top select
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
    bus_en = 1'b0;
  endtask

  task automatic win_rd(string req, logic [7:0] s, logic [31:0] exp);
    bus_wr(8'h00, {24'h0, s});
    bus_rd(req, 8'h10, exp);
  endtask

  task automatic wr_with_set(logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = d; hw_rirr_set[0] = 1'b1;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0; hw_rirr_set[0] = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R8 reset state
    bus_rd("R8 select", 8'h00, 32'h0);
    bus_rd("R8 id", 8'h10, 32'h0);
    win_rd("R8 last entry low", 8'h3E, 32'h0001_0000);
    win_rd("R8 last entry high", 8'h3F, 32'h0);

    for (int k = 0; k < NV; k++) begin
      bus_wr(8'h00, {24'h0, VEC[k][71:64]});
      if (VEC[k][79:76] == 4'd0) bus_wr(8'h10, VEC[k][63:32]);
      else bus_rd($sformatf("R%0d vector %0d", VEC[k][75:72], k), 8'h10, VEC[k][31:0]);
    end

    // R1 select keeps only the low byte
    bus_wr(8'h00, 32'h1234_5678);
    bus_rd("R1 select byte", 8'h00, 32'h0000_0078);
    // R11 other offsets
    bus_wr(8'h20, 32'h55);
    bus_rd("R11 select untouched", 8'h00, 32'h0000_0078);
    bus_rd("R11 read zero", 8'h20, 32'h0);
    bus_rd("R11 read zero 04", 8'h04, 32'h0);

    // pin 0: level, mask cleared
    bus_wr(8'h00, 32'h10);
    bus_wr(8'h10, 32'h0000_8030);
    chk("R9 mask pulse", {31'h0, mask_chg_vld}, 32'h1);
    chk("R9 mask pin", 32'(mask_chg_pin), 32'h0);
    chk("R9 mask value", {31'h0, mask_chg_val}, 32'h0);
    chk("R10 level strobe", {31'h0, lvl_wr_vld}, 32'h1);
    chk("R10 level pin", 32'(lvl_wr_pin), 32'h0);
    // R7 hardware sets remote-IRR
    @(negedge clk); hw_rirr_set[0] = 1'b1;
    @(posedge clk); #1 hw_rirr_set[0] = 1'b0;
    bus_rd("R7 rirr set", 8'h10, 32'h0000_C030);
    @(negedge clk); hw_busy[0] = 1'b1;
    @(posedge clk); #1;
    bus_wr(8'h10, 32'h0000_8031);
    chk("R9 no flip", {31'h0, mask_chg_vld}, 32'h0);
    chk("R10 level rewrite", {31'h0, lvl_wr_vld}, 32'h1);
    bus_rd("R7 status preserved", 8'h10, 32'h0000_D031);
    bus_wr(8'h00, 32'h11);
    bus_wr(8'h10, 32'h0100_0000);
    chk("R10 high-half strobe", {31'h0, lvl_wr_vld}, 32'h1);
    win_rd("R7 low after high write", 8'h10, 32'h0000_D031);
    // same cycle: edge write with set pulse
    wr_with_set(32'h0000_0031);
    chk("R10 no strobe on edge", {31'h0, lvl_wr_vld}, 32'h0);
    bus_rd("R7 edge clears rirr", 8'h10, 32'h0000_1031);
    @(negedge clk); hw_rirr_set[0] = 1'b1;
    @(posedge clk); #1 hw_rirr_set[0] = 1'b0;
    bus_rd("R7 set ignored on edge", 8'h10, 32'h0000_1031);
    // same cycle: level write with set pulse
    wr_with_set(32'h0000_8031);
    bus_rd("R7 level write keeps set", 8'h10, 32'h0000_D031);
    @(negedge clk); hw_rirr_clr[0] = 1'b1;
    @(posedge clk); #1 hw_rirr_clr[0] = 1'b0;
    bus_rd("R7 rirr clear", 8'h10, 32'h0000_9031);
    // R9 mask set again, pulse lasts one cycle
    bus_wr(8'h10, 32'h0001_8031);
    chk("R9 set pulse", {31'h0, mask_chg_vld}, 32'h1);
    chk("R9 set value", {31'h0, mask_chg_val}, 32'h1);
    @(posedge clk); #1;
    chk("R9 single cycle", {31'h0, mask_chg_vld}, 32'h0);
    // R9 non-zero pin
    bus_wr(8'h00, 32'h16);
    bus_wr(8'h10, 32'h0000_0040);
    chk("R9 pin 3 pulse", {31'h0, mask_chg_vld}, 32'h1);
    chk("R9 pin 3 index", 32'(mask_chg_pin), 32'h3);
    chk("R10 pin 3 edge", {31'h0, lvl_wr_vld}, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule